// File: doc/BRIEF.md
# Load-Linked Store-Conditional Monitor

This block keeps a single reservation for the atomic linked-load / conditional-store pair of a 32-bit core. A linked load reads one word from memory, returns it for the register file and remembers both the effective address and the value it read. A later conditional store succeeds only if its effective address equals the remembered one and memory still holds the remembered value. In that case the store data is written with a read-then-conditional-write sequence. A one-bit flag reports the outcome, and every conditional store drops the reservation, whether it succeeded or not.

The core hands over one decoded request at a time: the raw instruction word, the value of the base register and, for stores, the value of the data register. While the block works through its memory sequence it raises `busy` and ignores further requests. The memory port has a read strobe whose data comes back one cycle later, and a write strobe. Other processors and ordinary loads and stores are not handled here.

Top module: `llsc_monitor`

## Requirements
- R1: After reset `sc_flag` is 0, `busy` is 0, no strobe is active and no reservation exists. A conditional store issued before any linked load therefore fails without touching memory.
- R2: A request whose opcode (instruction bits 31:26) is 0x1B is a linked load. Its destination index is bits 25:21 and its offset is bits 15:0, sign-extended. The effective address is `req_base` plus that offset. In the cycle after acceptance the block drives `mem_re` with `mem_addr` equal to the effective address.
- R3: One cycle after the linked-load read, `rf_we` pulses for one cycle with `rf_waddr` equal to the destination index and `rf_wdata` equal to `mem_rdata`. When the destination index is 0, `rf_we` stays low.
- R4: A linked load stores its effective address and read value as the reservation, including when its destination index is 0. A second linked load replaces the first reservation.
- R5: A request with opcode 0x33 is a conditional store. Its 16-bit offset is {bits 25:21, bits 10:0}, sign-extended. Its effective address is `req_base` plus that offset, and its store data is `req_sdata`.
- R6: If the conditional store's effective address differs from the reservation address, no memory access happens and `sc_flag` is 0 from the edge that accepts the request. `busy` stays low.
- R7: If the addresses match, `mem_re` is driven for the reserved address in the next cycle. In the cycle after that, `mem_we` is driven with `req_sdata` only if `mem_rdata` equals the reserved value. From the following edge `sc_flag` equals the result of that comparison.
- R8: Every conditional store clears the reservation, so a repeat of the same conditional store fails as in R6.
- R9: `busy` rises on the edge that accepts a linked load or a matching conditional store and falls on the edge that completes the writeback or flag update. Requests presented while `busy` is high are ignored.
- R10: Requests with any other opcode have no effect: no strobe is driven, `sc_flag` is unchanged and the reservation is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_insn | input | 32 | Instruction word of the request |
| req_base | input | 32 | Base register value |
| req_sdata | input | 32 | Store data register value |
| busy | output | 1 | Memory sequence in progress |
| mem_re | output | 1 | Memory read strobe, data returned next cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 5 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| sc_flag | output | 1 | Conditional store success flag |

## Verification
Taking the accepting edge as edge 0, a linked load shows its read strobe after edge 0 and its register writeback after edge 1, and `busy` falls at edge 2. A mismatching conditional store has updated `sc_flag` right after edge 0. A matching one reads after edge 0, compares and may write after edge 1, and shows the flag after edge 2. The bench drives and samples only on falling edges, and at each falling edge it compares every output against the expectation that its behavioural model holds for that exact cycle. The model keeps its own copy of the reservation and reads the bench memory to decide what should happen.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  localparam int          INSN_W      = 32;
  localparam int          REG_IDX_W   = 5;
  localparam int          IMM_W       = 16;
  localparam logic [5:0]  OPC_LINK_LD = 6'h1B;
  localparam logic [5:0]  OPC_COND_ST = 6'h33;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_LINK,
    OP_COND
  } op_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LL_READ,
    ST_LL_WB,
    ST_SC_READ,
    ST_SC_CMP
  } seq_state_e;
endpackage

// File: rtl/llsc_decode.sv
module llsc_decode
  import llsc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [5:0]           opc,
  input  logic [4:0]           hi_field,
  input  logic [IMM_W-1:0]     lo_field,
  input  logic [AW-1:0]        base,
  output op_kind_e             kind,
  output logic [REG_IDX_W-1:0] dst,
  output logic [AW-1:0]        ea
);
  logic [IMM_W-1:0] imm;

  always_comb begin
    if (opc == OPC_LINK_LD)      kind = OP_LINK;
    else if (opc == OPC_COND_ST) kind = OP_COND;
    else                         kind = OP_NONE;
  end

  // loads carry a contiguous offset; conditional stores split it around the data index
  assign imm = (kind == OP_COND) ? {hi_field, lo_field[10:0]} : lo_field;
  assign dst = hi_field;
  assign ea  = base + {{(AW-IMM_W){imm[IMM_W-1]}}, imm};
endmodule

// File: rtl/llsc_resv.sv
module llsc_resv #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [AW-1:0] set_addr,
  input  logic [DW-1:0] set_data,
  input  logic          clr_en,
  output logic [AW-1:0] res_addr,
  output logic [DW-1:0] res_data
);
  logic [AW-1:0] addr_d, addr_q;
  logic [DW-1:0] data_d, data_q;

  always_comb begin
    addr_d = addr_q;
    data_d = data_q;
    if (set_en) begin
      addr_d = set_addr;
      data_d = set_data;
    end else if (clr_en) begin
      addr_d = '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '1;
      data_q <= '0;
    end else if (set_en || clr_en) begin
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign res_addr = addr_q;
  assign res_data = data_q;
endmodule

// File: rtl/llsc_seq.sv
module llsc_seq
  import llsc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  op_kind_e             kind,
  input  logic [AW-1:0]        ea,
  input  logic [REG_IDX_W-1:0] dst,
  input  logic [DW-1:0]        sdata,
  input  logic [AW-1:0]        res_addr,
  input  logic [DW-1:0]        res_data,
  input  logic [DW-1:0]        mem_rdata,
  output logic                 busy,
  output logic                 mem_re,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [DW-1:0]        mem_wdata,
  output logic                 rf_we,
  output logic [REG_IDX_W-1:0] rf_waddr,
  output logic                 res_set,
  output logic                 res_clr,
  output logic                 flag
);
  seq_state_e           state_d, state_q;
  logic [AW-1:0]        ea_d, ea_q;
  logic [DW-1:0]        sd_d, sd_q;
  logic [REG_IDX_W-1:0] rd_d, rd_q;
  logic                 flag_d, flag_q;
  logic                 cmp_hit;

  assign cmp_hit = (mem_rdata == res_data);

  always_comb begin
    state_d   = state_q;
    ea_d      = ea_q;
    sd_d      = sd_q;
    rd_d      = rd_q;
    flag_d    = flag_q;
    mem_re    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ea_q;
    mem_wdata = sd_q;
    rf_we     = 1'b0;
    res_set   = 1'b0;
    res_clr   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid && kind == OP_LINK) begin
          state_d = ST_LL_READ;
          ea_d    = ea;
          rd_d    = dst;
        end else if (req_valid && kind == OP_COND) begin
          if (ea == res_addr) begin
            state_d = ST_SC_READ;
            ea_d    = ea;
            sd_d    = sdata;
          end else begin
            flag_d  = 1'b0;
            res_clr = 1'b1;
          end
        end
      end
      ST_LL_READ: begin
        mem_re  = 1'b1;
        state_d = ST_LL_WB;
      end
      ST_LL_WB: begin
        rf_we   = (rd_q != '0);
        res_set = 1'b1;
        state_d = ST_IDLE;
      end
      ST_SC_READ: begin
        mem_re  = 1'b1;
        state_d = ST_SC_CMP;
      end
      ST_SC_CMP: begin
        mem_addr = res_addr;
        mem_we   = cmp_hit;
        flag_d   = cmp_hit;
        res_clr  = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      flag_q  <= 1'b0;
      ea_q    <= '0;
      sd_q    <= '0;
      rd_q    <= '0;
    end else begin
      state_q <= state_d;
      flag_q  <= flag_d;
      if (state_q == ST_IDLE) begin
        ea_q <= ea_d;
        sd_q <= sd_d;
        rd_q <= rd_d;
      end
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign rf_waddr = rd_q;
  assign flag     = flag_q;
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [INSN_W-1:0]    req_insn,
  input  logic [AW-1:0]        req_base,
  input  logic [DW-1:0]        req_sdata,
  output logic                 busy,
  output logic                 mem_re,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [DW-1:0]        mem_wdata,
  input  logic [DW-1:0]        mem_rdata,
  output logic                 rf_we,
  output logic [REG_IDX_W-1:0] rf_waddr,
  output logic [DW-1:0]        rf_wdata,
  output logic                 sc_flag
);
  op_kind_e             kind;
  logic [AW-1:0]        ea;
  logic [REG_IDX_W-1:0] dst;
  logic [AW-1:0]        res_addr;
  logic [DW-1:0]        res_data;
  logic                 res_set, res_clr;

  llsc_decode #(.AW(AW)) u_decode (
    .opc      (req_insn[31:26]),
    .hi_field (req_insn[25:21]),
    .lo_field (req_insn[15:0]),
    .base     (req_base),
    .kind     (kind),
    .dst      (dst),
    .ea       (ea)
  );

  llsc_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .kind      (kind),
    .ea        (ea),
    .dst       (dst),
    .sdata     (req_sdata),
    .res_addr  (res_addr),
    .res_data  (res_data),
    .mem_rdata (mem_rdata),
    .busy      (busy),
    .mem_re    (mem_re),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .rf_we     (rf_we),
    .rf_waddr  (rf_waddr),
    .res_set   (res_set),
    .res_clr   (res_clr),
    .flag      (sc_flag)
  );

  llsc_resv #(.AW(AW), .DW(DW)) u_resv (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (res_set),
    .set_addr (mem_addr),
    .set_data (mem_rdata),
    .clr_en   (res_clr),
    .res_addr (res_addr),
    .res_data (res_data)
  );

  assign rf_wdata = mem_rdata;
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int AW = 32,
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          busy,
  input logic          mem_re,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          rf_we,
  input logic [RW-1:0] rf_waddr,
  input logic          sc_flag
);
  a_r9_busy_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  a_r9_strobes_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re || mem_we || rf_we) |-> busy);

  a_r7_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(mem_re) && mem_addr == $past(mem_addr)));

  a_r7_flag_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sc_flag);

  a_r6_flag_rise_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sc_flag) |-> $past(mem_we));

  a_r3_no_zero_index: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> rf_waddr != '0);

  a_r3_wb_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> ($past(mem_re) && !mem_re));
endmodule

bind llsc_monitor llsc_monitor_chk #(.AW(AW), .RW(llsc_pkg::REG_IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .busy      (busy),
  .mem_re    (mem_re),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .rf_we     (rf_we),
  .rf_waddr  (rf_waddr),
  .sc_flag   (sc_flag)
);

// File: tb/llsc_monitor_bench.sv
`timescale 1ns/1ps
module llsc_monitor_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_insn, req_base, req_sdata;
  logic        busy, mem_re, mem_we, rf_we, sc_flag;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_wdata;
  logic [4:0]  rf_waddr;

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;

  logic [31:0] mem [logic [31:0]];
  logic [31:0] m_res_addr = 32'hFFFF_FFFF;
  logic [31:0] m_res_val  = 32'h0;
  logic        m_flag     = 1'b0;

  always #2.5 clk = ~clk;

  llsc_monitor u_llsc_monitor (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_insn(req_insn),
    .req_base(req_base), .req_sdata(req_sdata), .busy(busy), .mem_re(mem_re),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .sc_flag(sc_flag)
  );

  function automatic logic [31:0] rdm(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (mem_re) mem_rdata <= rdm(mem_addr);
    if (mem_we) mem[mem_addr] = mem_wdata;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc_check(input bit eb, input bit ere, input bit ewe, input bit erf,
                           input logic [31:0] eaddr, input logic [31:0] ewd,
                           input logic [4:0] erd, input logic [31:0] erdata, input string tag);
    chk(busy === eb,    {tag, " busy"},    busy,    eb);
    chk(sc_flag === m_flag, {tag, " flag"}, sc_flag, m_flag);
    chk(mem_re === ere, {tag, " mem_re"},  mem_re,  ere);
    chk(mem_we === ewe, {tag, " mem_we"},  mem_we,  ewe);
    chk(rf_we === erf,  {tag, " rf_we"},   rf_we,   erf);
    if (ere || ewe) chk(mem_addr === eaddr, {tag, " mem_addr"}, mem_addr, eaddr);
    if (ewe) chk(mem_wdata === ewd, {tag, " mem_wdata"}, mem_wdata, ewd);
    if (erf) begin
      chk(rf_waddr === erd,    {tag, " rf_waddr"}, {27'd0, rf_waddr}, {27'd0, erd});
      chk(rf_wdata === erdata, {tag, " rf_wdata"}, rf_wdata, erdata);
    end
  endtask

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  // linked load; junk keeps a request on the inputs while busy (R9)
  task automatic do_ll(input logic [4:0] rd, input logic [31:0] base, input logic [15:0] imm, input bit junk);
    logic [31:0] ea = base + sx(imm);
    logic [31:0] val;
    @(negedge clk);
    req_valid = 1'b1; req_insn = {6'h1B, rd, 5'd1, imm}; req_base = base;
    @(negedge clk);
    if (junk) begin
      req_insn = {6'h33, 5'd0, 5'd1, 5'd2, 11'd0}; req_base = ea; req_sdata = 32'hDEAD_0000;
    end else req_valid = 1'b0;
    val = rdm(ea);
    cyc_check(1, 1, 0, 0, ea, 0, 0, 0, "R2 ll read");
    @(negedge clk);
    cyc_check(1, 0, 0, rd != 0, 0, 0, rd, val, "R3 ll writeback");
    @(negedge clk);
    req_valid = 1'b0;
    m_res_addr = ea; m_res_val = val;
    cyc_check(0, 0, 0, 0, 0, 0, 0, 0, "R9 ll done");
  endtask

  task automatic do_sc(input logic [31:0] base, input logic [15:0] imm, input logic [31:0] sd, input string tag);
    logic [31:0] ea = base + sx(imm);
    logic [31:0] old;
    bit eq;
    bit hit = (ea == m_res_addr);
    @(negedge clk);
    req_valid = 1'b1; req_insn = {6'h33, imm[15:11], 5'd1, 5'd2, imm[10:0]};
    req_base = base; req_sdata = sd;
    @(negedge clk);
    req_valid = 1'b0;
    m_res_addr = 32'hFFFF_FFFF;
    if (!hit) begin
      m_flag = 1'b0;
      cyc_check(0, 0, 0, 0, 0, 0, 0, 0, {tag, " R6 miss"});
    end else begin
      cyc_check(1, 1, 0, 0, ea, 0, 0, 0, {tag, " R7 read"});
      old = rdm(ea);
      eq  = (old == m_res_val);
      @(negedge clk);
      cyc_check(1, 0, eq, 0, ea, sd, 0, 0, {tag, " R7 compare"});
      @(negedge clk);
      m_flag = eq;
      cyc_check(0, 0, 0, 0, 0, 0, 0, 0, {tag, " R7 flag"});
      chk(rdm(ea) === (eq ? sd : old), {tag, " R7 memory"}, rdm(ea), eq ? sd : old);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_insn = '0; req_base = '0; req_sdata = '0;
    mem[32'h100] = 32'hAAAA_5555; mem[32'h1FC] = 32'h1111_2222; mem[32'h308] = 32'h0BAD_F00D;
    mem[32'h500] = 32'h5;  mem[32'h600] = 32'h6;  mem[32'h700] = 32'h7;
    mem[32'h800] = 32'h8;  mem[32'h900] = 32'h9;  mem[32'h904] = 32'h9;
    repeat (3) @(negedge clk);
    cyc_check(0, 0, 0, 0, 0, 0, 0, 0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    cyc_check(0, 0, 0, 0, 0, 0, 0, 0, "R1 after reset");
    do_sc(32'h100, 16'h0000, 32'h1, "R1 no reservation");

    do_ll(5'd4, 32'h100, 16'h0000, 0);
    do_sc(32'h0F0, 16'h0010, 32'h1234_5678, "R5 positive offset");
    do_sc(32'h0F0, 16'h0010, 32'h8765_4321, "R8 repeat store");

    do_ll(5'd7, 32'h200, 16'hFFFC, 0);
    mem[32'h1FC] = 32'h3333_4444;
    do_sc(32'h1FC, 16'h0000, 32'hCAFE_0001, "R7 value changed");

    do_ll(5'd0, 32'h300, 16'h0008, 0);
    do_sc(32'h400, 16'hFF08, 32'hCAFE_0002, "R4 R5 zero index negative offset");

    do_ll(5'd9, 32'h500, 16'h0000, 0);
    do_ll(5'd10, 32'h600, 16'h0000, 0);
    do_sc(32'h500, 16'h0000, 32'hCAFE_0003, "R4 overwritten");
    do_ll(5'd10, 32'h600, 16'h0000, 0);
    do_sc(32'h600, 16'h0000, 32'hCAFE_0004, "R4 newest kept");

    do_ll(5'd11, 32'h700, 16'h0000, 1);
    do_sc(32'h700, 16'h0000, 32'hCAFE_0005, "R9 busy requests ignored");

    do_ll(5'd12, 32'h800, 16'h0000, 0);
    @(negedge clk);
    req_valid = 1'b1; req_insn = {6'h21, 5'd3, 5'd1, 16'h0}; req_base = 32'h800;
    @(negedge clk);
    req_valid = 1'b0;
    cyc_check(0, 0, 0, 0, 0, 0, 0, 0, "R10 other opcode");
    do_sc(32'h800, 16'h0000, 32'hCAFE_0006, "R10 reservation kept");

    do_ll(5'd13, 32'h900, 16'h0000, 0);
    do_sc(32'h904, 16'h0000, 32'hCAFE_0007, "R6 near address");
    chk(rdm(32'h904) === 32'h9, "R6 memory untouched", rdm(32'h904), 32'h9);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule